// File: doc/BRIEF.md
# Reconfigurable Byte-Pair Timer with PWM

The block holds two byte-wide counters that can run on their own, be chained into one wide counter, or act as the period counter of a pulse-width modulator. A two-bit mode input picks one of four arrangements: two separate interval timers, an interval timer next to an 8-bit PWM, one chained interval timer, or a PWM whose period spans a selectable 9 to 16 bits. The counters advance on a count strobe supplied from outside, so clock generation stays outside the block. In the two chained modes a resolution input can switch the counters to a second strobe that arrives twice as often.

Match values and duty values are loaded through a small write port. Each counter event produces a one-cycle flag, and the two flags are merged into a single interrupt request. The PWM waveform goes to one output pin. In the PWM modes a new duty value is held back until the running period ends, so the pin never shows a partial pulse.

Top module: `tmr_pair_pwm`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pwm_o`, `ovf_lo_o`, `ovf_hi_o` and `irq_o` are all low, and all counters, match and duty registers start from zero.
- R2: In mode 0 (`mode_i` = 0) the low counter advances once per `step_i` pulse; on a step while it equals the low match value (write address 0) it returns to zero and `ovf_lo_o` is high for the following cycle.
- R3: In mode 0 the high counter behaves in the same way on its own match value (write address 1) and raises `ovf_hi_o`, independently of the low counter.
- R4: In modes 0 and 1 only `step_i` moves the counters; `half_step_i` and `fine_i` have no effect.
- R5: In mode 1 the low counter is the interval timer of R2, and the high counter runs freely from 0 to 255; `pwm_o` is high while the high counter is below the active duty byte (write address 3), and `ovf_hi_o` pulses for one cycle after the step that wraps 255 to 0.
- R6: In mode 2 the counters form one 16-bit counter (high byte above low byte) that returns to zero on a step while it equals {match high, match low}; only `ovf_hi_o` reports that event and `ovf_lo_o` stays low.
- R7: In mode 3 the 16-bit counter has a period of 2^W steps with W = 9 + `width_sel_i`; it wraps to zero on the step after reaching 2^W-1, raises `ovf_hi_o` for one cycle, and `pwm_o` is high while the counter is below the active duty {duty high (address 3), duty low (address 2)} limited to W bits.
- R8: In modes 2 and 3, `fine_i` = 1 makes `half_step_i` the counting strobe in place of `step_i`.
- R9: A duty of zero keeps `pwm_o` low for whole periods; a duty of all ones within the active width (255 in mode 1, 2^W-1 in mode 3) keeps it high.
- R10: A duty write takes effect only at the start of the next PWM period or on entry to a PWM mode; until then the old duty keeps shaping `pwm_o`.
- R11: `irq_o` is high in exactly the cycles where `ovf_lo_o` or `ovf_hi_o` is high.
- R12: When `mode_i` changes, on the following cycle both counters are zero and both flags are low.
- R13: In modes 0 and 2 `pwm_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Count strobe at cycle rate |
| half_step_i | input | 1 | Count strobe at twice cycle rate |
| mode_i | input | 2 | Arrangement: 0 split, 1 timer+PWM, 2 chained, 3 variable-width PWM |
| fine_i | input | 1 | In modes 2 and 3, count on `half_step_i` |
| width_sel_i | input | WSEL_W (3) | PWM period width in mode 3 is 9 + this value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 match low, 1 match high, 2 duty low, 3 duty high |
| wr_data_i | input | HALF_W (8) | Write data |
| pwm_o | output | 1 | PWM waveform |
| ovf_lo_o | output | 1 | Low counter event, one cycle |
| ovf_hi_o | output | 1 | High or wide counter event, one cycle |
| irq_o | output | 1 | Merged event request |

## Verification
The properties assume that `width_sel_i` is not changed while mode 3 runs, because a narrower width mid-period would leave the counter above the new period bound; the stimulus only moves it while another mode is selected. They also assume the strobes and write port change only between clock edges, which the bench respects by driving every input shortly after the rising edge. Strobe patterns run both in a fixed alternating rhythm and in a pseudo-random one, and mode changes are issued while counters are mid-count.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

   typedef enum logic [1:0] {
      TM_SPLIT   = 2'd0,
      TM_TMR_PWM = 2'd1,
      TM_CASCADE = 2'd2,
      TM_VARPWM  = 2'd3
   } tpw_mode_e;

   localparam int unsigned NUM_REGS    = 4;
   localparam logic [1:0]  RA_MATCH_LO = 2'd0;
   localparam logic [1:0]  RA_MATCH_HI = 2'd1;
   localparam logic [1:0]  RA_DUTY_LO  = 2'd2;
   localparam logic [1:0]  RA_DUTY_HI  = 2'd3;

endpackage

// File: rtl/tpw_regs.sv
module tpw_regs
   import tpw_pkg::*;
#(
   parameter int unsigned HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [HALF_W-1:0] wr_data_i,
   output logic [HALF_W-1:0] match_lo_o,
   output logic [HALF_W-1:0] match_hi_o,
   output logic [HALF_W-1:0] duty_lo_o,
   output logic [HALF_W-1:0] duty_hi_o
);

   logic [NUM_REGS-1:0][HALF_W-1:0] bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else if (wr_en_i) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_addr_i == 2'(i)) bank_q[i] <= wr_data_i;
         end
      end
   end

   assign match_lo_o = bank_q[RA_MATCH_LO];
   assign match_hi_o = bank_q[RA_MATCH_HI];
   assign duty_lo_o  = bank_q[RA_DUTY_LO];
   assign duty_hi_o  = bank_q[RA_DUTY_HI];

endmodule

// File: rtl/tpw_counters.sv
module tpw_counters
   import tpw_pkg::*;
#(
   parameter int unsigned HALF_W = 8,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tpw_mode_e         mode_q,
   input  logic              mode_chg_i,
   input  logic              step_i,
   input  logic              adv_i,
   input  logic [HALF_W-1:0] match_lo_i,
   input  logic [HALF_W-1:0] match_hi_i,
   input  logic [CNT_W-1:0]  mask_i,
   output logic [HALF_W-1:0] cnt_lo_o,
   output logic [HALF_W-1:0] cnt_hi_o,
   output logic              ovf_lo_o,
   output logic              ovf_hi_o,
   output logic              period_end_o
);

   logic [1:0][HALF_W-1:0] cnt_q, cnt_n, match_v, byte_next;
   logic [1:0]             hit, flag_q, flag_n;
   logic [CNT_W-1:0]       wide_q, wide_match;

   assign match_v    = {match_hi_i, match_lo_i};
   assign wide_q     = cnt_q;
   assign wide_match = match_v;

   for (genvar gb = 0; gb < 2; gb++) begin : g_byte
      assign hit[gb]       = (cnt_q[gb] == match_v[gb]);
      assign byte_next[gb] = hit[gb] ? '0 : cnt_q[gb] + 1'b1;
   end

   always_comb begin
      cnt_n        = cnt_q;
      flag_n       = '0;
      period_end_o = 1'b0;
      unique case (mode_q)
         TM_SPLIT: begin
            if (step_i) begin
               cnt_n  = byte_next;
               flag_n = hit;
            end
         end
         TM_TMR_PWM: begin
            if (step_i) begin
               cnt_n[0]  = byte_next[0];
               flag_n[0] = hit[0];
               cnt_n[1]  = cnt_q[1] + 1'b1;
               if (&cnt_q[1]) begin
                  flag_n[1]    = 1'b1;
                  period_end_o = 1'b1;
               end
            end
         end
         TM_CASCADE: begin
            if (adv_i) begin
               if (wide_q == wide_match) begin
                  cnt_n     = '0;
                  flag_n[1] = 1'b1;
               end else begin
                  cnt_n = wide_q + 1'b1;
               end
            end
         end
         TM_VARPWM: begin
            if (adv_i) begin
               if (wide_q >= mask_i) begin
                  cnt_n        = '0;
                  flag_n[1]    = 1'b1;
                  period_end_o = 1'b1;
               end else begin
                  cnt_n = wide_q + 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= '0;
      end else if (mode_chg_i) begin
         cnt_q  <= '0;
         flag_q <= '0;
      end else begin
         cnt_q  <= cnt_n;
         flag_q <= flag_n;
      end
   end

   assign cnt_lo_o = cnt_q[0];
   assign cnt_hi_o = cnt_q[1];
   assign ovf_lo_o = flag_q[0];
   assign ovf_hi_o = flag_q[1];

endmodule

// File: rtl/tpw_pwm.sv
module tpw_pwm
   import tpw_pkg::*;
#(
   parameter int unsigned HALF_W = 8,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tpw_mode_e         mode_q,
   input  tpw_mode_e         mode_in,
   input  logic              mode_chg_i,
   input  logic              period_end_i,
   input  logic [HALF_W-1:0] duty_lo_i,
   input  logic [HALF_W-1:0] duty_hi_i,
   input  logic [CNT_W-1:0]  mask_i,
   input  logic [HALF_W-1:0] cnt_lo_i,
   input  logic [HALF_W-1:0] cnt_hi_i,
   output logic [CNT_W-1:0]  duty_act_o,
   output logic              pwm_o
);

   logic [CNT_W-1:0] duty_q, narrow_src, wide_src, wide_cnt, wide_duty;
   logic [HALF_W-1:0] narrow_duty;

   assign narrow_src = {{HALF_W{1'b0}}, duty_hi_i};
   assign wide_src   = {duty_hi_i, duty_lo_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0;
      end else if (mode_chg_i) begin
         duty_q <= (mode_in == TM_TMR_PWM) ? narrow_src : wide_src;
      end else if (period_end_i) begin
         duty_q <= (mode_q == TM_TMR_PWM) ? narrow_src : wide_src;
      end
   end

   assign narrow_duty = duty_q[HALF_W-1:0];
   assign wide_cnt    = {cnt_hi_i, cnt_lo_i};
   assign wide_duty   = duty_q & mask_i;

   always_comb begin
      unique case (mode_q)
         TM_TMR_PWM: pwm_o = (&narrow_duty) || (cnt_hi_i < narrow_duty);
         TM_VARPWM:  pwm_o = (wide_duty == mask_i) || (wide_cnt < wide_duty);
         default:    pwm_o = 1'b0;
      endcase
   end

   assign duty_act_o = duty_q;

endmodule

// File: rtl/tmr_pair_pwm.sv
module tmr_pair_pwm
   import tpw_pkg::*;
#(
   parameter int unsigned HALF_W  = 8,
   parameter bit          FINE_EN = 1'b1,
   localparam int unsigned CNT_W  = 2 * HALF_W,
   localparam int unsigned WSEL_W = $clog2(HALF_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              half_step_i,
   input  logic [1:0]        mode_i,
   input  logic              fine_i,
   input  logic [WSEL_W-1:0] width_sel_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [HALF_W-1:0] wr_data_i,
   output logic              pwm_o,
   output logic              ovf_lo_o,
   output logic              ovf_hi_o,
   output logic              irq_o
);

   if (HALF_W < 2 || (HALF_W & (HALF_W - 1)) != 0) begin : g_bad_half_w
      $error("tmr_pair_pwm: HALF_W must be a power of two of at least 2");
   end

   tpw_mode_e         mode_in, mode_q;
   logic              mode_chg, adv, period_end;
   logic [HALF_W-1:0] match_lo, match_hi, duty_lo, duty_hi, cnt_lo, cnt_hi;
   logic [CNT_W-1:0]  mask, duty_act;
   logic [WSEL_W-1:0] shamt;

   assign mode_in  = tpw_mode_e'(mode_i);
   assign mode_chg = (mode_in != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= TM_SPLIT;
      else        mode_q <= mode_in;
   end

   assign shamt = WSEL_W'(HALF_W - 1) - width_sel_i;
   assign mask  = {CNT_W{1'b1}} >> shamt;

   if (FINE_EN) begin : g_fine
      assign adv = ((mode_q == TM_CASCADE || mode_q == TM_VARPWM) && fine_i)
                   ? half_step_i : step_i;
   end else begin : g_coarse
      logic unused_fine;
      assign unused_fine = fine_i ^ half_step_i;
      assign adv         = step_i;
   end

   tpw_regs #(.HALF_W(HALF_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .match_lo_o (match_lo),
      .match_hi_o (match_hi),
      .duty_lo_o  (duty_lo),
      .duty_hi_o  (duty_hi)
   );

   tpw_counters #(.HALF_W(HALF_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_q       (mode_q),
      .mode_chg_i   (mode_chg),
      .step_i       (step_i),
      .adv_i        (adv),
      .match_lo_i   (match_lo),
      .match_hi_i   (match_hi),
      .mask_i       (mask),
      .cnt_lo_o     (cnt_lo),
      .cnt_hi_o     (cnt_hi),
      .ovf_lo_o     (ovf_lo_o),
      .ovf_hi_o     (ovf_hi_o),
      .period_end_o (period_end)
   );

   tpw_pwm #(.HALF_W(HALF_W)) u_pwm (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_q       (mode_q),
      .mode_in      (mode_in),
      .mode_chg_i   (mode_chg),
      .period_end_i (period_end),
      .duty_lo_i    (duty_lo),
      .duty_hi_i    (duty_hi),
      .mask_i       (mask),
      .cnt_lo_i     (cnt_lo),
      .cnt_hi_i     (cnt_hi),
      .duty_act_o   (duty_act),
      .pwm_o        (pwm_o)
   );

   assign irq_o = ovf_lo_o | ovf_hi_o;

endmodule

// File: rtl/tpw_checker.sv
module tpw_checker #(
   parameter int unsigned HALF_W = 8,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic [1:0]        mode_q,
   input logic              step_i,
   input logic [HALF_W-1:0] cnt_lo,
   input logic [HALF_W-1:0] cnt_hi,
   input logic [HALF_W-1:0] match_lo,
   input logic [CNT_W-1:0]  mask,
   input logic [CNT_W-1:0]  duty_act,
   input logic              period_end,
   input logic              ovf_lo_o,
   input logic              ovf_hi_o,
   input logic              pwm_o
);

   // R12: a new mode leaves counters and flags cleared
   a_r12_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != mode_q) |=> (cnt_lo == '0 && cnt_hi == '0 && !ovf_lo_o && !ovf_hi_o));

   // R2: split-mode low byte returns to zero at its match and flags it
   a_r2_lo_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == mode_q && mode_q == 2'd0 && step_i && cnt_lo == match_lo)
      |=> (cnt_lo == '0 && ovf_lo_o));

   // R4: without a cycle-rate strobe the byte modes stand still
   a_r4_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == mode_q && mode_q <= 2'd1 && !step_i)
      |=> ($stable(cnt_lo) && $stable(cnt_hi) && !ovf_lo_o && !ovf_hi_o));

   // R6: the chained counter never reports on the low flag
   a_r6_cascade_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd2) |-> !ovf_lo_o);

   // R7: the variable-width counter never leaves its period
   a_r7_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd3) |-> ({cnt_hi, cnt_lo} <= mask));

   // R9: zero duty in the wide PWM keeps the pin low
   a_r9_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd3 && (duty_act & mask) == '0) |-> !pwm_o);

   // R10: active duty only moves at a period boundary
   a_r10_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == mode_q && !period_end) |=> $stable(duty_act));

   // R13: timer-only modes keep the pin low
   a_r13_timer_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0 || mode_q == 2'd2) |-> !pwm_o);

endmodule

bind tmr_pair_pwm tpw_checker #(.HALF_W(HALF_W)) u_tpw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .mode_q     (mode_q),
   .step_i     (step_i),
   .cnt_lo     (cnt_lo),
   .cnt_hi     (cnt_hi),
   .match_lo   (match_lo),
   .mask       (mask),
   .duty_act   (duty_act),
   .period_end (period_end),
   .ovf_lo_o   (ovf_lo_o),
   .ovf_hi_o   (ovf_hi_o),
   .pwm_o      (pwm_o)
);

// File: tb/tmr_pair_pwm_bench.sv
module tmr_pair_pwm_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 1'b0;
   logic       half_step_i = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic       fine_i = 1'b0;
   logic [2:0] width_sel_i = 3'd0;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_addr_i = 2'd0;
   logic [7:0] wr_data_i = 8'd0;
   logic       pwm_o, ovf_lo_o, ovf_hi_o, irq_o;

   int checks = 0;
   int errors = 0;
   int wd = 0;
   string cur_req = "R1 reset";
   bit irregular = 1'b0;
   bit phase = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference state
   int m_mode, m_cl, m_ch, m_fl, m_fh, m_da;
   int r_ml, r_mh, r_dl, r_dh;

   tmr_pair_pwm u_tmr_pair_pwm (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step_i),
      .half_step_i (half_step_i),
      .mode_i      (mode_i),
      .fine_i      (fine_i),
      .width_sel_i (width_sel_i),
      .wr_en_i     (wr_en_i),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .pwm_o       (pwm_o),
      .ovf_lo_o    (ovf_lo_o),
      .ovf_hi_o    (ovf_hi_o),
      .irq_o       (irq_o)
   );

   always #10 clk = ~clk;

   function automatic int period_mask();
      return (1 << (9 + int'(width_sel_i))) - 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_cl = 0; m_ch = 0; m_fl = 0; m_fh = 0; m_da = 0;
         r_ml = 0; r_mh = 0; r_dl = 0; r_dh = 0;
      end else begin
         int c, msk, adv;
         msk = period_mask();
         if (int'(mode_i) != m_mode) begin
            m_mode = int'(mode_i);
            m_cl = 0; m_ch = 0; m_fl = 0; m_fh = 0;
            m_da = (m_mode == 1) ? r_dh : r_dh * 256 + r_dl;
         end else begin
            m_fl = 0; m_fh = 0;
            adv = (m_mode >= 2 && fine_i) ? int'(half_step_i) : int'(step_i);
            c = m_ch * 256 + m_cl;
            case (m_mode)
               0: if (step_i) begin
                     if (m_cl == r_ml) begin m_cl = 0; m_fl = 1; end else m_cl = (m_cl + 1) % 256;
                     if (m_ch == r_mh) begin m_ch = 0; m_fh = 1; end else m_ch = (m_ch + 1) % 256;
                  end
               1: if (step_i) begin
                     if (m_cl == r_ml) begin m_cl = 0; m_fl = 1; end else m_cl = (m_cl + 1) % 256;
                     if (m_ch == 255) begin m_ch = 0; m_fh = 1; m_da = r_dh; end else m_ch = m_ch + 1;
                  end
               2: if (adv != 0) begin
                     if (c == r_mh * 256 + r_ml) begin c = 0; m_fh = 1; end else c = (c + 1) % 65536;
                     m_cl = c % 256; m_ch = c / 256;
                  end
               default: if (adv != 0) begin
                     if (c >= msk) begin c = 0; m_fh = 1; m_da = r_dh * 256 + r_dl; end else c = c + 1;
                     m_cl = c % 256; m_ch = c / 256;
                  end
            endcase
         end
         if (wr_en_i) begin
            case (wr_addr_i)
               2'd0: r_ml = int'(wr_data_i);
               2'd1: r_mh = int'(wr_data_i);
               2'd2: r_dl = int'(wr_data_i);
               default: r_dh = int'(wr_data_i);
            endcase
         end
      end
   end

   function automatic bit exp_pwm();
      int dm, msk;
      if (m_mode == 1) return (m_da == 255) || (m_ch < m_da);
      if (m_mode == 3) begin
         msk = period_mask();
         dm = m_da & msk;
         return (dm == msk) || ((m_ch * 256 + m_cl) < dm);
      end
      return 1'b0;
   endfunction

   always @(negedge clk) begin
      logic [3:0] act, exp;
      act = {pwm_o, ovf_lo_o, ovf_hi_o, irq_o};
      exp = {exp_pwm(), m_fl[0], m_fh[0], (m_fl | m_fh) != 0};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (R11 irq, flags, pin) at %0t: actual pwm/lo/hi/irq=%b expected=%b",
                  cur_req, $time, act, exp);
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         errors++;
         $display("FAIL watchdog expired: actual cycles=%0d expected below 100000", wd);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic drive_strobes();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (irregular) begin
         half_step_i = lfsr[1] | lfsr[0];
         step_i      = lfsr[0] & lfsr[3];
      end else begin
         phase       = ~phase;
         half_step_i = 1'b1;
         step_i      = phase;
      end
   endtask

   task automatic run(input int n);
      repeat (n) begin
         @(posedge clk); #5;
         wr_en_i = 1'b0;
         drive_strobes();
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #5;
      drive_strobes();
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(posedge clk); #5;
      wr_en_i = 1'b0;
      drive_strobes();
      mode_i = m;
   endtask

   initial begin
      // R1: reset state at the pins
      repeat (3) @(posedge clk);
      #15;
      checks++;
      if ({pwm_o, ovf_lo_o, ovf_hi_o, irq_o} !== 4'b0000) begin
         errors++;
         $display("FAIL R1 reset: actual=%b expected=0000", {pwm_o, ovf_lo_o, ovf_hi_o, irq_o});
      end
      @(posedge clk); #5; rst_n = 1'b1;
      run(4);

      cur_req = "R2/R3 split timers";
      wr(2'd0, 8'd5); wr(2'd1, 8'd9);
      run(120);
      cur_req = "R4 split ignores half strobe and fine select";
      fine_i = 1'b1; irregular = 1'b1;
      run(300);
      fine_i = 1'b0; irregular = 1'b0;
      wr(2'd0, 8'd0);
      cur_req = "R2 match zero wraps every step";
      run(20);
      wr(2'd0, 8'd3);

      cur_req = "R5 timer plus pwm";
      wr(2'd3, 8'd100);
      set_mode(2'd1);
      run(1100);
      cur_req = "R10 duty change waits for period end";
      wr(2'd3, 8'd200);
      run(1100);
      cur_req = "R9 mode1 duty zero";
      wr(2'd3, 8'd0);
      run(1100);
      cur_req = "R9 mode1 duty full";
      wr(2'd3, 8'd255);
      fine_i = 1'b1; irregular = 1'b1;
      run(1200);
      fine_i = 1'b0; irregular = 1'b0;

      cur_req = "R12 mode change mid-count";
      wr(2'd0, 8'h2C); wr(2'd1, 8'h01);
      set_mode(2'd2);
      cur_req = "R6/R13 cascade at cycle rate";
      run(1300);
      cur_req = "R8 cascade at half-cycle rate";
      fine_i = 1'b1;
      run(700);
      irregular = 1'b1;
      run(500);
      irregular = 1'b0;

      cur_req = "R7 variable width 9 bits";
      width_sel_i = 3'd0;
      wr(2'd2, 8'h40); wr(2'd3, 8'h01);
      set_mode(2'd3);
      run(1300);
      cur_req = "R9 mode3 duty full width";
      wr(2'd2, 8'hFF);
      run(1100);
      cur_req = "R9 mode3 duty zero";
      wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      run(1100);

      cur_req = "R12 leave and re-enter with wider period";
      set_mode(2'd0);
      run(6);
      width_sel_i = 3'd2;
      wr(2'd2, 8'h20); wr(2'd3, 8'h03);
      set_mode(2'd3);
      cur_req = "R7/R8 variable width 11 bits";
      run(4300);
      cur_req = "R8 mode3 at cycle rate";
      fine_i = 1'b0;
      run(600);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule